// File: doc/BRIEF.md
# Subsystem Receive Staging Buffer with Commit

This block sits on the subsystem side of a serial data bus remote terminal. It collects receive data words that the terminal delivers as two byte strobes over an 8-bit highway. It assembles each pair of bytes into a 16-bit word and writes the words in arrival order into a staging region of `DEPTH` words (32 by default). It answers each per-word transfer request with an acknowledge. The subsystem's local logic cannot see the staged words. The terminal's good-block pulse commits them, and only then do they appear, together with their word count, at a local read port.

Storage is two banks of `DEPTH` words. One bank is staging and the other is committed. A commit flips the bank select, so the data and the count change on the same clock edge. The old committed bank then becomes the new staging area. A start-of-block pulse rewinds the staging write pointer, which throws away whatever was staged and never committed. All terminal-side inputs are taken to be synchronous to `clk`. `DEPTH` must be a power of two.

Top module: `rx_stage_buf`

## Requirements
- R1: After reset, `dtak_n` is 1, `commit_valid` is 0, `commit_count` is 0 and `overflow` is 0.
- R2: On the first clock edge at which `dtrq_n` is sampled 0 after having been 1, `dtak_n` goes to 0.
- R3: `dtak_n` returns to 1 on the edge that captures a low byte, and it is 1 whenever `dtrq_n` was 1 at the previous edge.
- R4: A rising edge of `iustb` while `dtrq_n` is 1 captures nothing.
- R5: A rising edge of `iustb` with `dtrq_n` = 0 and `hl` = 1 holds the highway as the high byte. A rising edge with `hl` = 0 writes the word {high byte, highway} to the next staging address, starting at 0.
- R6: Staged words change neither `commit_count` nor `rd_data` until a good-block pulse arrives.
- R7: On the edge that samples `gbr_n` falling, `commit_count` becomes the number of staged words and `commit_valid` becomes 1. `rd_data` at address i then returns the i-th staged word.
- R8: A falling `nbgt_n` discards all staged words, so the next commit holds only words received after it.
- R9: A low byte that arrives after `DEPTH` words are staged is not stored and sets `overflow`. A falling `nbgt_n` clears `overflow`.
- R10: The committed block stays readable, unchanged, while the next block is being staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nbgt_n | input | 1 | Start-of-block pulse, active low |
| dtrq_n | input | 1 | Per-word transfer request, active low |
| dtak_n | output | 1 | Transfer acknowledge, active low |
| iustb | input | 1 | Byte strobe, captured on its rising edge |
| hl | input | 1 | Byte select: 1 selects the high byte, 0 the low byte |
| hwy | input | WORD_W/2 | Byte highway |
| gbr_n | input | 1 | Good-block commit pulse, active low |
| rd_addr | input | $clog2(DEPTH) | Read address into the committed block |
| rd_data | output | WORD_W | Committed word at `rd_addr` |
| commit_count | output | $clog2(DEPTH+1) | Word count of the committed block |
| commit_valid | output | 1 | A block has been committed since reset |
| overflow | output | 1 | The current block exceeded `DEPTH` words |

## Verification
The bench builds the block with `DEPTH` = 4 and the default 16-bit word. With that depth a block can be filled completely, and then pushed past full, in a handful of transfers, which makes the overflow and full-count boundaries cheap to exercise. Two successive commits each swap the banks, so the bench reads both banks in both roles and checks that the committed data holds while the next block is staged. The same run also covers a block that is discarded before its commit, and a strobe that arrives with no transfer request.

// File: rtl/rx_stage_buf.sv
module rx_stage_buf #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         nbgt_n,
  input  logic                         dtrq_n,
  output logic                         dtak_n,
  input  logic                         iustb,
  input  logic                         hl,
  input  logic [WORD_W/2-1:0]          hwy,
  input  logic                         gbr_n,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [WORD_W-1:0]            rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   commit_count,
  output logic                         commit_valid,
  output logic                         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int BW = WORD_W / 2;

  logic            nbgt_q, dtrq_q, iustb_q, gbr_q;
  logic            cbank;
  logic [CW-1:0]   wptr;
  logic [BW-1:0]   hi_byte;
  logic [WORD_W-1:0] mem [2*DEPTH];

  wire nbgt_fall = nbgt_q & ~nbgt_n;
  wire gbr_fall  = gbr_q & ~gbr_n;
  wire dtrq_fall = dtrq_q & ~dtrq_n;
  wire strobe    = iustb & ~iustb_q & ~dtrq_n;
  wire full      = (wptr == CW'(DEPTH));
  wire hi_cap    = strobe & hl;
  wire lo_cap    = strobe & ~hl;
  wire wr_en     = lo_cap & ~full & ~nbgt_fall & ~gbr_fall;

  assign rd_data = mem[{cbank, rd_addr}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbgt_q  <= 1'b1;
      dtrq_q  <= 1'b1;
      iustb_q <= 1'b0;
      gbr_q   <= 1'b1;
    end else begin
      nbgt_q  <= nbgt_n;
      dtrq_q  <= dtrq_n;
      iustb_q <= iustb;
      gbr_q   <= gbr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dtak_n <= 1'b1;
    else if (dtrq_n)       dtak_n <= 1'b1;
    else if (lo_cap)       dtak_n <= 1'b1;
    else if (dtrq_fall)    dtak_n <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr         <= '0;
      hi_byte      <= '0;
      cbank        <= 1'b0;
      commit_count <= '0;
      commit_valid <= 1'b0;
      overflow     <= 1'b0;
    end else if (nbgt_fall) begin
      wptr     <= '0;
      overflow <= 1'b0;
    end else if (gbr_fall) begin
      cbank        <= ~cbank;
      commit_count <= wptr;
      commit_valid <= 1'b1;
      wptr         <= '0;
    end else begin
      if (hi_cap) hi_byte <= hwy;
      if (lo_cap && full) overflow <= 1'b1;
      if (wr_en) wptr <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{~cbank, wptr[AW-1:0]}] <= {hi_byte, hwy};
  end

  assert_dtak_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dtrq_fall && !iustb) |=> !dtak_n);
  assert_dtak_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dtrq_n |=> dtak_n);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= CW'(DEPTH));
  assert_hidden_until_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gbr_fall |=> ($stable(commit_count) && $stable(cbank)));
  assert_commit_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gbr_fall && !nbgt_fall) |=> (commit_valid && commit_count == $past(wptr)));
  assert_block_start_rewinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nbgt_fall |=> (wptr == '0 && !overflow));
endmodule

// File: tb/rx_stage_buf_tb.sv
module rx_stage_buf_tb;
  localparam int DEPTH  = 4;
  localparam int WORD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nbgt_n = 1'b1, dtrq_n = 1'b1, iustb = 1'b0, hl = 1'b0, gbr_n = 1'b1;
  logic [7:0]  hwy = '0;
  logic [1:0]  rd_addr = '0;
  logic        dtak_n, commit_valid, overflow;
  logic [15:0] rd_data;
  logic [2:0]  commit_count;

  int vecs = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_stage_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .nbgt_n(nbgt_n), .dtrq_n(dtrq_n), .dtak_n(dtak_n),
    .iustb(iustb), .hl(hl), .hwy(hwy), .gbr_n(gbr_n), .rd_addr(rd_addr),
    .rd_data(rd_data), .commit_count(commit_count), .commit_valid(commit_valid),
    .overflow(overflow));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, input bit check_ack);
    dtrq_n = 1'b0; step();
    if (check_ack) chk("R2 dtak low after request", dtak_n, 1'b0);
    hl = 1'b1; hwy = w[15:8]; iustb = 1'b1; step();
    iustb = 1'b0; step();
    hl = 1'b0; hwy = w[7:0]; iustb = 1'b1; step();
    if (check_ack) chk("R3 dtak high after low byte", dtak_n, 1'b1);
    iustb = 1'b0; dtrq_n = 1'b1; step();
    if (check_ack) chk("R3 dtak high while idle", dtak_n, 1'b1);
  endtask

  task automatic pulse_nbgt();
    nbgt_n = 1'b0; step(); nbgt_n = 1'b1; step();
  endtask

  task automatic pulse_gbr();
    gbr_n = 1'b0; step(); gbr_n = 1'b1; step();
  endtask

  task automatic read_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    chk("R1 dtak_n", dtak_n, 1'b1);
    chk("R1 commit_valid", commit_valid, 1'b0);
    chk("R1 commit_count", commit_count, 3'd0);
    chk("R1 overflow", overflow, 1'b0);
  endtask

  task automatic t_basic_commit();
    pulse_nbgt();
    send_word(16'hAA55, 1);
    send_word(16'h1234, 1);
    chk("R6 count before commit", commit_count, 3'd0);
    chk("R6 valid before commit", commit_valid, 1'b0);
    pulse_gbr();
    chk("R7 count", commit_count, 3'd2);
    chk("R7 valid", commit_valid, 1'b1);
    read_chk("R5 R7 word0", 2'd0, 16'hAA55);
    read_chk("R5 R7 word1", 2'd1, 16'h1234);
  endtask

  task automatic t_ignore_no_request();
    pulse_nbgt();
    hl = 1'b1; hwy = 8'hEE; iustb = 1'b1; step(); iustb = 1'b0; step();
    hl = 1'b0; hwy = 8'hDD; iustb = 1'b1; step(); iustb = 1'b0; step();
    chk("R4 dtak stays high", dtak_n, 1'b1);
    send_word(16'h0F0F, 0);
    read_chk("R10 old word0 while staging", 2'd0, 16'hAA55);
    chk("R6 count unchanged while staging", commit_count, 3'd2);
    pulse_gbr();
    chk("R4 stray strobes not counted", commit_count, 3'd1);
    read_chk("R4 first word is the real one", 2'd0, 16'h0F0F);
  endtask

  task automatic t_discard();
    pulse_nbgt();
    send_word(16'hDEAD, 0);
    send_word(16'hBEEF, 0);
    send_word(16'hCAFE, 0);
    pulse_nbgt();
    send_word(16'h5A5A, 0);
    read_chk("R10 committed held", 2'd0, 16'h0F0F);
    pulse_gbr();
    chk("R8 count after discard", commit_count, 3'd1);
    read_chk("R8 data after discard", 2'd0, 16'h5A5A);
  endtask

  task automatic t_overflow();
    pulse_nbgt();
    send_word(16'h1111, 0);
    send_word(16'h2222, 0);
    send_word(16'h3333, 0);
    send_word(16'h4444, 0);
    chk("R9 no overflow at full", overflow, 1'b0);
    send_word(16'h5555, 0);
    chk("R9 overflow set", overflow, 1'b1);
    pulse_gbr();
    chk("R9 count capped", commit_count, 3'd4);
    read_chk("R9 last word", 2'd3, 16'h4444);
    read_chk("R5 order word2", 2'd2, 16'h3333);
    pulse_nbgt();
    chk("R9 overflow cleared", overflow, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic_commit();
    t_ignore_no_request();
    t_discard();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule